// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller Core

This core arbitrates eight interrupt request lines for a processor. Each line is captured into a request register, either as a level that follows the pin or as a sticky rising-edge event; a per-line trigger-mode register picks which. Requests that are not masked compete under a priority order that starts at a movable base position and wraps around. The winner is compared against the most urgent line already in service. The interrupt output is raised only when the new request strictly outranks it.

The surrounding logic acknowledges the interrupt with a one-cycle pulse. The pulse moves the granted line into service. The surrounding logic then retires it with end-of-interrupt commands: non-specific (most urgent in-service line), specific (a named line), and variants of both that also rotate the priority base. A set-base command moves the priority base without retiring anything. An automatic end-of-interrupt mode retires the line at acknowledge time and can optionally rotate the base. Bus decoding, the initialization sequence and the chaining of two cores live outside. They reach the core as strobes with an operand.

Top module: `irqc_core`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level mode) has its request bit equal to its input as sampled on the previous rising clock edge, both when the input is high and when it is low.
- R2: A line whose trigger-mode bit is 0 (edge mode) sets its request bit only when the input is high and was low on the previous edge. The bit stays set while the input is low, and a held-high input does not set it again once it has been cleared.
- R3: The candidate request is found by scanning the unmasked request bits from position (base + k) mod 8, for k = 0 to 7. The first set bit wins, and its k is its level (0 most urgent; 8 means none). A mask bit of 1 removes that line.
- R4: `int_o` is 1 exactly when the candidate request level is strictly smaller than the level of the most urgent in-service bit, scanned under the same base. `int_vec_o` is (level + base) mod 8.
- R5: An acknowledge pulse while `int_o` is 1 sets the in-service bit of `int_vec_o` and clears that request bit only in edge mode. An acknowledge while `int_o` is 0 changes nothing.
- R6: With `auto_eoi_i` high, an accepted acknowledge leaves the in-service register unchanged. If `rot_auto_i` is also high, the base becomes (granted line + 1) mod 8.
- R7: Command code 1 clears the most urgent in-service bit. Code 2 does the same and sets the base to (that line + 1) mod 8. With no bit in service, both leave every register unchanged.
- R8: Code 3 clears the in-service bit named by `cmd_arg_i`. Code 4 also sets the base to (operand + 1) mod 8. Code 5 sets the base to (operand + 1) mod 8 and leaves the in-service bits alone. Codes 0, 6 and 7 do nothing.
- R9: In the master variant, with `nested_i` high, in-service bit 2 (the chained input) is left out of the in-service level used by R4.
- R10: A trigger-mode write stores the data ANDed with the fixed write mask (0xF8 master, 0xDE slave). Bits outside the mask always read 0 (edge mode).
- R11: When an acknowledge and an end-of-interrupt command arrive in the same cycle, the acknowledge is applied first, and the command acts on the in-service register and base it produced.
- R12: Synchronous active-high reset clears the request, in-service, mask and trigger-mode registers, the last-level register and the base to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 8 | Interrupt request lines |
| ack_i | input | 1 | Acknowledge pulse |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (see R7, R8) |
| cmd_arg_i | input | 3 | Command operand (line number) |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_data_i | input | 8 | Mask write data, 1 = masked |
| trig_wr_i | input | 1 | Trigger-mode write strobe |
| trig_data_i | input | 8 | Trigger-mode write data, 1 = level |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt mode |
| rot_auto_i | input | 1 | Rotate base on automatic end-of-interrupt |
| nested_i | input | 1 | Exclude chained input from in-service level |
| int_o | output | 1 | Interrupt request to the processor |
| int_vec_o | output | 3 | Line number of the pending interrupt |
| irr_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |
| imr_o | output | 8 | Mask register |
| trig_o | output | 8 | Trigger-mode register |
| base_o | output | 3 | Priority base |

## Verification
The arbitration is swept over every mask value at each of the eight base positions with all requests latched. This separates the wrap-around scan from a fixed-order encoder. A second sweep places each line in service in turn and again walks all 256 masks. It shows whether the compare is strict, since a request at the same level as the in-service line must not fire. Directed sequences drive edge and level lines through acknowledge and end-of-interrupt. They show whether a level request survives acknowledge while an edge request is consumed and not re-armed by a held input. Further sequences cover automatic retirement with and without rotation, the chained-input exclusion, and an acknowledge that collides with a rotating command.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE         = 3'd0,
        CMD_EOI          = 3'd1,
        CMD_EOI_ROT      = 3'd2,
        CMD_EOI_SPEC     = 3'd3,
        CMD_EOI_SPEC_ROT = 3'd4,
        CMD_SET_BASE     = 3'd5,
        CMD_RSV6         = 3'd6,
        CMD_RSV7         = 3'd7
    } irqc_cmd_e;

endpackage

// File: rtl/irqc_prio_scan.sv
module irqc_prio_scan #(
    parameter int N = 8
) (
    input  logic [N-1:0]               vec_i,
    input  logic [$clog2(N)-1:0]       base_i,
    output logic [$clog2(N+1)-1:0]     level_o,
    output logic [$clog2(N)-1:0]       index_o,
    output logic                       any_o
);
    localparam int IW = $clog2(N);
    localparam int LW = $clog2(N + 1);

    // Walk from the least urgent slot down so that the most urgent set slot is written last.
    always_comb begin
        level_o = LW'(N);
        for (int k = N - 1; k >= 0; k--) begin
            if (vec_i[base_i + IW'(k)]) begin
                level_o = LW'(k);
            end
        end
    end

    assign any_o   = (level_o != LW'(N));
    assign index_o = base_i + level_o[IW-1:0];

endmodule

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] trig_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] irr_o
);
    logic [N-1:0] irr_q;
    logic [N-1:0] last_q;
    logic [N-1:0] irr_d;
    logic [N-1:0] rise;

    assign rise = req_in & ~last_q;

    // Level lines mirror the pin; edge lines keep their bit until consumed.
    always_comb begin
        irr_d = (trig_i & req_in) | (~trig_i & ((irr_q & ~clr_i) | rise));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q  <= '0;
            last_q <= '0;
        end else begin
            irr_q  <= irr_d;
            last_q <= req_in;
        end
    end

    assign irr_o = irr_q;

endmodule

// File: rtl/irqc_svc_ctrl.sv
module irqc_svc_ctrl
    import irqc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take_i,
    input  logic [$clog2(N)-1:0] grant_i,
    input  logic                 auto_eoi_i,
    input  logic                 rot_auto_i,
    input  logic                 cmd_valid_i,
    input  logic [2:0]           cmd_op_i,
    input  logic [$clog2(N)-1:0] cmd_arg_i,
    output logic [N-1:0]         isr_o,
    output logic [$clog2(N)-1:0] base_o
);
    localparam int IW = $clog2(N);
    localparam int LW = $clog2(N + 1);

    logic [N-1:0]  isr_q, isr_a, isr_d;
    logic [IW-1:0] base_q, base_a, base_d;
    logic [LW-1:0] hi_level;
    logic [IW-1:0] hi_index;
    logic          hi_any;
    irqc_cmd_e     cmd;

    // Stage one: the acknowledge.
    always_comb begin
        isr_a  = isr_q;
        base_a = base_q;
        if (take_i) begin
            isr_a[grant_i] = 1'b1;
            if (auto_eoi_i) begin
                isr_a[grant_i] = 1'b0;
                if (rot_auto_i) begin
                    base_a = grant_i + IW'(1);
                end
            end
        end
    end

    irqc_prio_scan #(.N(N)) u_isr_scan (
        .vec_i   (isr_a),
        .base_i  (base_a),
        .level_o (hi_level),
        .index_o (hi_index),
        .any_o   (hi_any)
    );

    assign cmd = cmd_valid_i ? irqc_cmd_e'(cmd_op_i) : CMD_IDLE;

    // Stage two: the command, applied to what the acknowledge left.
    always_comb begin
        isr_d  = isr_a;
        base_d = base_a;
        unique case (cmd)
            CMD_IDLE: begin
            end
            CMD_EOI, CMD_EOI_ROT: begin
                if (hi_any) begin
                    isr_d[hi_index] = 1'b0;
                    if (cmd == CMD_EOI_ROT) begin
                        base_d = hi_index + IW'(1);
                    end
                end
            end
            CMD_EOI_SPEC: begin
                isr_d[cmd_arg_i] = 1'b0;
            end
            CMD_EOI_SPEC_ROT: begin
                isr_d[cmd_arg_i] = 1'b0;
                base_d           = cmd_arg_i + IW'(1);
            end
            CMD_SET_BASE: begin
                base_d = cmd_arg_i + IW'(1);
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q  <= '0;
            base_q <= '0;
        end else begin
            isr_q  <= isr_d;
            base_q <= base_d;
        end
    end

    assign isr_o  = isr_q;
    assign base_o = base_q;

    logic unused_level;
    assign unused_level = ^hi_level;

endmodule

// File: rtl/irqc_core.sv
module irqc_core #(
    parameter int           NUM_IN     = 8,
    parameter logic [7:0]   TRIG_WMASK = 8'hF8,
    parameter bit           IS_MASTER  = 1'b1,
    parameter int           CASC_IDX   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_IN-1:0]         req_in,
    input  logic                      ack_i,
    input  logic                      cmd_valid_i,
    input  logic [2:0]                cmd_op_i,
    input  logic [$clog2(NUM_IN)-1:0] cmd_arg_i,
    input  logic                      mask_wr_i,
    input  logic [NUM_IN-1:0]         mask_data_i,
    input  logic                      trig_wr_i,
    input  logic [NUM_IN-1:0]         trig_data_i,
    input  logic                      auto_eoi_i,
    input  logic                      rot_auto_i,
    input  logic                      nested_i,
    output logic                      int_o,
    output logic [$clog2(NUM_IN)-1:0] int_vec_o,
    output logic [NUM_IN-1:0]         irr_o,
    output logic [NUM_IN-1:0]         isr_o,
    output logic [NUM_IN-1:0]         imr_o,
    output logic [NUM_IN-1:0]         trig_o,
    output logic [$clog2(NUM_IN)-1:0] base_o
);
    localparam int IW = $clog2(NUM_IN);
    localparam int LW = $clog2(NUM_IN + 1);
    localparam logic [NUM_IN-1:0] WMASK = NUM_IN'(TRIG_WMASK);

    logic [NUM_IN-1:0] imr_q, trig_q;
    logic [NUM_IN-1:0] irr, isr, isr_cmp, excl, clr;
    logic [IW-1:0]     base;
    logic [LW-1:0]     req_level, cur_level;
    logic [IW-1:0]     req_index, cur_index;
    logic              req_any, cur_any;
    logic              take;

    always_ff @(posedge clk) begin
        if (rst) begin
            imr_q  <= '0;
            trig_q <= '0;
        end else begin
            if (mask_wr_i) imr_q  <= mask_data_i;
            if (trig_wr_i) trig_q <= trig_data_i & WMASK;
        end
    end

    generate
        if (IS_MASTER) begin : g_master
            assign excl = nested_i ? (NUM_IN'(1) << CASC_IDX) : '0;
        end else begin : g_slave
            assign excl = '0;
            logic unused_nested;
            assign unused_nested = nested_i;
        end
    endgenerate

    assign isr_cmp = isr & ~excl;

    irqc_prio_scan #(.N(NUM_IN)) u_req_scan (
        .vec_i   (irr & ~imr_q),
        .base_i  (base),
        .level_o (req_level),
        .index_o (req_index),
        .any_o   (req_any)
    );

    irqc_prio_scan #(.N(NUM_IN)) u_cur_scan (
        .vec_i   (isr_cmp),
        .base_i  (base),
        .level_o (cur_level),
        .index_o (cur_index),
        .any_o   (cur_any)
    );

    assign int_o     = req_any && (req_level < cur_level);
    assign int_vec_o = req_index;
    assign take      = ack_i && int_o;
    assign clr       = take ? ((NUM_IN'(1) << req_index) & ~trig_q) : '0;

    irqc_req_latch #(.N(NUM_IN)) u_req (
        .clk    (clk),
        .rst    (rst),
        .req_in (req_in),
        .trig_i (trig_q),
        .clr_i  (clr),
        .irr_o  (irr)
    );

    irqc_svc_ctrl #(.N(NUM_IN)) u_svc (
        .clk         (clk),
        .rst         (rst),
        .take_i      (take),
        .grant_i     (req_index),
        .auto_eoi_i  (auto_eoi_i),
        .rot_auto_i  (rot_auto_i),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (cmd_op_i),
        .cmd_arg_i   (cmd_arg_i),
        .isr_o       (isr),
        .base_o      (base)
    );

    assign irr_o  = irr;
    assign isr_o  = isr;
    assign imr_o  = imr_q;
    assign trig_o = trig_q;
    assign base_o = base;

    logic unused_cur;
    assign unused_cur = cur_any ^ (^cur_index);

endmodule

// File: rtl/irqc_core_chk.sv
module irqc_core_chk #(
    parameter int         N     = 8,
    parameter logic [7:0] WMASK = 8'hF8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N-1:0]         req_in,
    input logic                 ack_i,
    input logic                 cmd_valid_i,
    input logic [2:0]           cmd_op_i,
    input logic [$clog2(N)-1:0] cmd_arg_i,
    input logic                 trig_wr_i,
    input logic                 auto_eoi_i,
    input logic                 int_o,
    input logic [$clog2(N)-1:0] int_vec_o,
    input logic [N-1:0]         irr_o,
    input logic [N-1:0]         isr_o,
    input logic [N-1:0]         imr_o,
    input logic [N-1:0]         trig_o,
    input logic [$clog2(N)-1:0] base_o
);
    localparam int IW = $clog2(N);

    a_r1_level_follow: assert property (@(posedge clk) disable iff (rst)
        !trig_wr_i |=> (((irr_o ^ $past(req_in)) & trig_o) == '0));

    a_r2_edge_hold: assert property (@(posedge clk) disable iff (rst)
        (!ack_i && !trig_wr_i) |=>
            (((irr_o & ~trig_o) & $past(irr_o & ~trig_o)) == $past(irr_o & ~trig_o)));

    a_r4_vec_unmasked: assert property (@(posedge clk) disable iff (rst)
        int_o |-> (irr_o[int_vec_o] && !imr_o[int_vec_o]));

    a_r5_ack_sets_isr: assert property (@(posedge clk) disable iff (rst)
        (ack_i && int_o && !auto_eoi_i && !cmd_valid_i) |=> isr_o[$past(int_vec_o)]);

    a_r6_auto_no_isr: assert property (@(posedge clk) disable iff (rst)
        (ack_i && int_o && auto_eoi_i && !cmd_valid_i) |=> (isr_o == $past(isr_o)));

    a_r8_set_base: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && cmd_op_i == 3'd5) |=> (base_o == IW'($past(cmd_arg_i) + IW'(1))));

    a_r10_trig_mask: assert property (@(posedge clk) disable iff (rst)
        $past(trig_wr_i) |-> ((trig_o & ~N'(WMASK)) == '0));

    a_r12_reset_clear: assert property (@(posedge clk)
        rst |=> (isr_o == '0 && irr_o == '0 && base_o == '0 && imr_o == '0));

endmodule

bind irqc_core irqc_core_chk #(.N(NUM_IN), .WMASK(TRIG_WMASK)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_in      (req_in),
    .ack_i       (ack_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_arg_i   (cmd_arg_i),
    .trig_wr_i   (trig_wr_i),
    .auto_eoi_i  (auto_eoi_i),
    .int_o       (int_o),
    .int_vec_o   (int_vec_o),
    .irr_o       (irr_o),
    .isr_o       (isr_o),
    .imr_o       (imr_o),
    .trig_o      (trig_o),
    .base_o      (base_o)
);

// File: tb/irqc_core_tb.sv
module irqc_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req = '0;
    logic       ack = 1'b0;
    logic       cv = 1'b0;
    logic [2:0] cop = '0;
    logic [2:0] carg = '0;
    logic       mwr = 1'b0;
    logic [7:0] mdat = '0;
    logic       twr = 1'b0;
    logic [7:0] tdat = '0;
    logic       aeoi = 1'b0;
    logic       raeoi = 1'b0;
    logic       nest = 1'b0;
    logic       int_o;
    logic [2:0] vec, base;
    logic [7:0] irr, isr, imr, trig;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irqc_core dut_i (
        .clk(clk), .rst(rst), .req_in(req), .ack_i(ack),
        .cmd_valid_i(cv), .cmd_op_i(cop), .cmd_arg_i(carg),
        .mask_wr_i(mwr), .mask_data_i(mdat), .trig_wr_i(twr), .trig_data_i(tdat),
        .auto_eoi_i(aeoi), .rot_auto_i(raeoi), .nested_i(nest),
        .int_o(int_o), .int_vec_o(vec), .irr_o(irr), .isr_o(isr),
        .imr_o(imr), .trig_o(trig), .base_o(base)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; req = '0; ack = 0; cv = 0; mwr = 0; twr = 0;
        aeoi = 0; raeoi = 0; nest = 0;
        tick(); tick();
        rst = 1'b0;
        #1;
    endtask

    task automatic pulse(input logic [7:0] v);
        req = v; tick();
        req = '0; tick();
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0; #1;
    endtask

    task automatic cmd(input int op, input int arg);
        cv = 1'b1; cop = 3'(op); carg = 3'(arg); tick(); cv = 1'b0; #1;
    endtask

    task automatic wmask(input logic [7:0] v);
        mwr = 1'b1; mdat = v; tick(); mwr = 1'b0; #1;
    endtask

    task automatic wtrig(input logic [7:0] v);
        twr = 1'b1; tdat = v; tick(); twr = 1'b0; #1;
    endtask

    function automatic int best_lvl(input logic [7:0] v, input int b);
        for (int k = 0; k < 8; k++) if (v[(b + k) % 8]) return k;
        return 8;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R12: reset state
        chk(irr == 0 && isr == 0 && imr == 0 && trig == 0 && base == 0 && !int_o,
            "R12 reset state", {irr, isr, imr, trig}, 0);

        // R10: every trigger-mode write value
        for (int v = 0; v < 256; v++) begin
            wtrig(8'(v));
            chk(trig == (8'(v) & 8'hF8), "R10 trig write mask", trig, v & 8'hF8);
        end

        // R3/R4 sweep: all requests latched, every base, every mask
        do_reset();
        wmask(8'hFF);
        pulse(8'hFF);
        for (int b = 0; b < 8; b++) begin
            cmd(5, (b + 7) % 8);
            chk(base == 3'(b), "R8 set base", base, b);
            for (int m = 0; m < 256; m++) begin
                logic [7:0] rq;
                int lv;
                wmask(8'(m));
                rq = ~8'(m);
                lv = best_lvl(rq, b);
                chk(int_o == (lv < 8), "R3 pending flag", int_o, lv < 8);
                if (lv < 8) chk(vec == 3'((b + lv) % 8), "R3 rotating vector", vec, (b + lv) % 8);
            end
        end

        // R4 sweep: one line in service, every mask, base 0
        cmd(5, 7);
        for (int s = 0; s < 8; s++) begin
            wmask(~(8'h01 << s));
            do_ack();
            chk(isr == (8'h01 << s), "R5 ack sets isr", isr, 1 << s);
            chk(irr == ~(8'h01 << s), "R5 edge request consumed", irr, 8'hFF ^ (1 << s));
            for (int m = 0; m < 256; m++) begin
                int lv;
                wmask(8'(m));
                lv = best_lvl(irr & ~8'(m), 0);
                chk(int_o == (lv < s), "R4 strict compare", int_o, lv < s);
                if (lv < s) chk(vec == 3'(lv), "R4 vector", vec, lv);
            end
            cmd(3, s);
            pulse(8'h01 << s);
            chk(isr == 0 && irr == 8'hFF, "R8 specific eoi restore", {isr, irr}, 8'hFF);
        end

        // R1/R2/R5/R7 directed
        do_reset();
        wtrig(8'hF8);
        req = 8'h20; tick();
        chk(irr == 8'h20, "R1 level set", irr, 8'h20);
        req = 8'h00; tick();
        chk(irr == 8'h00, "R1 level clear", irr, 0);
        req = 8'h01; tick();
        chk(irr == 8'h01, "R2 edge set", irr, 1);
        req = 8'h00; tick();
        chk(irr == 8'h01, "R2 edge held low", irr, 1);
        req = 8'h02; tick();
        chk(int_o && vec == 0, "R3 best of two", vec, 0);
        do_ack();
        chk(isr == 8'h01 && irr == 8'h02, "R5 edge ack", {isr, irr}, 16'h0102);
        chk(!int_o, "R4 lower request blocked", int_o, 0);
        cmd(1, 0);
        chk(isr == 0 && int_o && vec == 1, "R7 non-specific eoi", {isr, 5'(vec)}, 1);
        do_ack();
        chk(irr == 0 && isr == 8'h02, "R2 held high no retrigger", {isr, irr}, 16'h0200);
        req = 8'h08; tick();
        chk(irr == 8'h08 && !int_o, "R4 below in-service", {irr, 7'(int_o)}, 16'h0800);
        cmd(1, 0);
        chk(int_o && vec == 3, "R7 eoi releases", vec, 3);
        do_ack();
        chk(isr == 8'h08 && irr == 8'h08, "R5 level request kept", {isr, irr}, 16'h0808);
        req = 8'h00; tick();
        chk(irr == 0 && !int_o, "R1 level drop", irr, 0);
        do_ack();
        chk(isr == 8'h08 && base == 0, "R5 ack without pending ignored", isr, 8'h08);
        cmd(2, 0);
        chk(isr == 0 && base == 4, "R7 rotating eoi", {isr, 5'(base)}, 4);
        cmd(2, 0);
        chk(isr == 0 && base == 4, "R7 eoi with empty isr", base, 4);
        cmd(4, 6);
        chk(base == 7 && isr == 0, "R8 specific rotate", base, 7);
        cmd(6, 1);
        chk(base == 7 && isr == 0, "R8 reserved code no-op", base, 7);
        cmd(5, 2);
        chk(base == 3, "R8 set base", base, 3);

        // R8: specific eoi on a non-top bit
        do_reset();
        pulse(8'h30);
        do_ack();
        chk(isr == 8'h10 && irr == 8'h20, "R5 grant line 4", {isr, irr}, 16'h1020);
        pulse(8'h02);
        chk(int_o && vec == 1, "R4 preempt", vec, 1);
        do_ack();
        cmd(3, 4);
        chk(isr == 8'h02, "R8 specific clears named bit", isr, 2);
        cmd(5, 7);
        chk(isr == 8'h02 && base == 0, "R8 set base keeps isr", isr, 2);
        cmd(1, 0);
        chk(isr == 0 && int_o && vec == 5, "R7 then pending line 5", vec, 5);

        // R6: automatic end of interrupt
        do_reset();
        aeoi = 1; raeoi = 1;
        pulse(8'h44);
        do_ack();
        chk(isr == 0 && irr == 8'h40 && base == 3, "R6 auto rotate", {isr, irr, 5'(base)}, 16'h0040);
        chk(int_o && vec == 6, "R6 next pending", vec, 6);
        do_ack();
        chk(base == 7 && irr == 0, "R6 rotate again", base, 7);
        raeoi = 0;
        pulse(8'h01);
        do_ack();
        chk(base == 7 && isr == 0 && irr == 0, "R6 auto without rotate", base, 7);

        // R9: chained-input exclusion
        do_reset();
        nest = 1;
        pulse(8'h04);
        do_ack();
        pulse(8'h04);
        chk(isr == 8'h04 && int_o && vec == 2, "R9 nested re-request", {isr, 5'(vec)}, 16'h0402);
        nest = 0; #1;
        chk(!int_o, "R9 plain nesting blocks", int_o, 0);

        // R11: acknowledge and rotating eoi together
        do_reset();
        pulse(8'h09);
        ack = 1; cv = 1; cop = 3'd2; carg = 0;
        tick();
        ack = 0; cv = 0; #1;
        chk(isr == 0 && base == 1 && irr == 8'h08, "R11 ack before eoi", {isr, irr, 5'(base)}, 16'h0008);
        chk(int_o && vec == 3, "R11 next pending", vec, 3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule